// File: doc/BRIEF.md
# Software Write-Protection Sequence Gate

This block sits between the captured bus writes of a byte-addressed non-volatile array and its page-write engine. For every write it is offered (an address, a data word and a one-cycle valid strobe), it decides whether the write may reach the array. It also marks writes that were taken up as command bytes. A command byte is never stored.

Software controls a single protection flag, which is clear after reset. Protection is armed by a three-write unlock prefix. The prefix must then be followed by a genuine data write. That data write is stored, and from then on protection is active. While protection is active, a write is accepted only inside the load window that follows a freshly entered prefix. The window ends when the write engine reports that the load window has expired. A six-write release sequence turns protection off again. Each write's decision appears on registered outputs one clock after its strobe.

Top module: `swp_gate`

## Requirements
- R1: After reset, protection is off, the decision outputs are idle, and the sequence tracker is in its idle step.
- R2: Each write strobe produces exactly one decision one clock later (`dec_valid` high for one cycle). With protection off, a write that is not a sequence byte passes with `dec_cmd` low.
- R3: The unlock prefix is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. The third byte is reported with `dec_cmd`=1 and `dec_pass`=0. Completing the prefix by itself leaves the protection flag unchanged.
- R4: The first write after a completed prefix passes, is not a command byte, and leaves protection on.
- R5: With protection on and no prefix granted, every write is blocked. Sequence bytes that the tracker accepts carry `dec_cmd`=1.
- R6: After a prefix, writes keep passing until a `window_expired` pulse arrives. Writes after that pulse are blocked again.
- R7: The release sequence is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. It clears protection on its last byte. Every byte from the 0x80 byte onward is a command byte (`dec_cmd`=1, `dec_pass`=0), whatever the protection state.
- R8: A write that does not match the next expected sequence byte returns the tracker to idle and is judged as an ordinary write. That write is not itself taken as a fresh first byte.
- R9: Sequence matching looks only at the low 15 address bits and the low data byte. Address 0x15555 with data 0xDEAD00AA therefore counts as the first sequence byte.
- R10: Address 0x0AAAA is accepted for the second step, in the same way as 0x2AAA.
- R11: With protection off, the first two bytes of either sequence pass to the array as ordinary writes (`dec_cmd`=0, `dec_pass`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe for a captured write |
| wr_addr | input | ADDR_W (17) | Captured write address |
| wr_data | input | DATA_W (32) | Captured write data |
| window_expired | input | 1 | Pulse from the write engine when the page load window closes |
| dec_valid | output | 1 | Decision for the write strobed one cycle earlier |
| dec_pass | output | 1 | The write may be stored |
| dec_cmd | output | 1 | The write was a command byte and is not stored |
| prot_active | output | 1 | Protection flag |

## Verification
The gate is tried with plain writes, with complete unlock and release sequences, and with sequences broken at different steps. Each of these runs both with protection off and with protection on. Comparing the two runs separates "passes as ordinary data" from "blocked" and from "command byte". Variants of the prefix that use an upper address bit, a dirty upper data word and the alternate second address show that matching is confined to the low bits. A window-expiry pulse placed between granted writes shows where permission ends. A mismatched byte followed by the rest of a sequence shows that the tracker really restarts from idle.

// File: rtl/swp_pkg.sv
package swp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_P1,
      ST_P2,
      ST_D3,
      ST_D4,
      ST_D5
   } swp_step_e;

   typedef enum logic [2:0] {
      TK_OTHER,
      TK_LEAD,
      TK_SECOND,
      TK_UNLOCK,
      TK_ARM,
      TK_RELEASE
   } swp_tok_e;

   localparam logic [15:0] SWP_ADDR_KEY  = 16'h5555;
   localparam logic [15:0] SWP_ADDR_ALTH = 16'hAAAA;
   localparam logic [15:0] SWP_ADDR_ALTL = 16'h2AAA;
   localparam int          SWP_BYTE_W    = 8;

   localparam logic [7:0] SWP_D_LEAD    = 8'hAA;
   localparam logic [7:0] SWP_D_SECOND  = 8'h55;
   localparam logic [7:0] SWP_D_UNLOCK  = 8'hA0;
   localparam logic [7:0] SWP_D_ARM     = 8'h80;
   localparam logic [7:0] SWP_D_RELEASE = 8'h20;

endpackage

// File: rtl/swp_match.sv
module swp_match
   import swp_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 32,
   parameter int CMP_ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output swp_tok_e          tok
);
   localparam int BW = SWP_BYTE_W;

   logic [CMP_ADDR_W-1:0] a_lo;
   logic [BW-1:0]         d_lo;
   logic                  at_key;
   logic                  at_alt;

   assign a_lo   = addr[CMP_ADDR_W-1:0];
   assign d_lo   = data[BW-1:0];
   assign at_key = (a_lo == SWP_ADDR_KEY[CMP_ADDR_W-1:0]);

   // Narrow compare: both second-step addresses fold to one pattern.
   generate
      if (CMP_ADDR_W <= 15) begin : g_alt_single
         assign at_alt = (a_lo == SWP_ADDR_ALTL[CMP_ADDR_W-1:0]);
      end else begin : g_alt_dual
         assign at_alt = (a_lo == SWP_ADDR_ALTL[CMP_ADDR_W-1:0]) ||
                         (a_lo == SWP_ADDR_ALTH[CMP_ADDR_W-1:0]);
      end
   endgenerate

   generate
      if (ADDR_W > CMP_ADDR_W) begin : g_addr_hi
         logic unused_addr_hi;
         assign unused_addr_hi = ^addr[ADDR_W-1:CMP_ADDR_W];
      end
      if (DATA_W > BW) begin : g_data_hi
         logic unused_data_hi;
         assign unused_data_hi = ^data[DATA_W-1:BW];
      end
   endgenerate

   always_comb begin
      tok = TK_OTHER;
      if (at_key && d_lo == SWP_D_LEAD)         tok = TK_LEAD;
      else if (at_alt && d_lo == SWP_D_SECOND)  tok = TK_SECOND;
      else if (at_key && d_lo == SWP_D_UNLOCK)  tok = TK_UNLOCK;
      else if (at_key && d_lo == SWP_D_ARM)     tok = TK_ARM;
      else if (at_key && d_lo == SWP_D_RELEASE) tok = TK_RELEASE;
   end
endmodule

// File: rtl/swp_tracker.sv
module swp_tracker
   import swp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_valid,
   input  logic      bypass,
   input  swp_tok_e  tok,
   output swp_step_e cur_step,
   output logic      step_hit,
   output logic      done_unlock,
   output logic      done_release
);
   swp_step_e step_q, step_n;
   logic      hit_c, unl_c, rel_c;
   logic      take;

   assign take = wr_valid && !bypass;

   always_comb begin
      step_n = ST_IDLE;
      hit_c  = 1'b0;
      unl_c  = 1'b0;
      rel_c  = 1'b0;
      unique case (step_q)
         ST_IDLE: if (tok == TK_LEAD)   begin step_n = ST_P1; hit_c = 1'b1; end
         ST_P1:   if (tok == TK_SECOND) begin step_n = ST_P2; hit_c = 1'b1; end
         ST_P2: begin
            if (tok == TK_UNLOCK) begin
               hit_c = 1'b1;
               unl_c = 1'b1;
            end else if (tok == TK_ARM) begin
               step_n = ST_D3;
               hit_c  = 1'b1;
            end
         end
         ST_D3:   if (tok == TK_LEAD)   begin step_n = ST_D4; hit_c = 1'b1; end
         ST_D4:   if (tok == TK_SECOND) begin step_n = ST_D5; hit_c = 1'b1; end
         ST_D5: begin
            if (tok == TK_RELEASE) begin
               hit_c = 1'b1;
               rel_c = 1'b1;
            end
         end
         default: step_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    step_q <= ST_IDLE;
      else if (take) step_q <= step_n;
   end

   assign cur_step     = step_q;
   assign step_hit     = take && hit_c;
   assign done_unlock  = take && unl_c;
   assign done_release = take && rel_c;
endmodule

// File: rtl/swp_guard.sv
module swp_guard
   import swp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_valid,
   input  logic      window_expired,
   input  swp_step_e cur_step,
   input  logic      step_hit,
   input  logic      done_unlock,
   input  logic      done_release,
   output logic      grant_q,
   output logic      prot_q,
   output logic      dec_valid,
   output logic      dec_pass,
   output logic      dec_cmd
);
   logic early_step;
   logic cmd_c;
   logic pass_c;

   // First two bytes only commit to nothing; they are data when unprotected.
   assign early_step = (cur_step == ST_IDLE) || (cur_step == ST_P1);
   assign cmd_c      = step_hit && (!early_step || prot_q);
   assign pass_c     = wr_valid && !cmd_c && (!prot_q || grant_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q   <= 1'b0;
         prot_q    <= 1'b0;
         dec_valid <= 1'b0;
         dec_pass  <= 1'b0;
         dec_cmd   <= 1'b0;
      end else begin
         dec_valid <= wr_valid;
         dec_pass  <= pass_c;
         dec_cmd   <= wr_valid && cmd_c;
         if (done_unlock)         grant_q <= 1'b1;
         else if (window_expired) grant_q <= 1'b0;
         if (done_release)             prot_q <= 1'b0;
         else if (wr_valid && grant_q) prot_q <= 1'b1;
      end
   end
endmodule

// File: rtl/swp_gate.sv
module swp_gate
   import swp_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 32,
   parameter int CMP_ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              window_expired,
   output logic              dec_valid,
   output logic              dec_pass,
   output logic              dec_cmd,
   output logic              prot_active
);
   generate
      if (CMP_ADDR_W > ADDR_W || CMP_ADDR_W > 16 || CMP_ADDR_W < 14) begin : g_bad_cmp
         $error("swp_gate: CMP_ADDR_W out of range");
      end
      if (DATA_W < SWP_BYTE_W) begin : g_bad_data
         $error("swp_gate: DATA_W below one byte");
      end
   endgenerate

   swp_tok_e  tok;
   swp_step_e cur_step;
   logic      step_hit, done_unlock, done_release;
   logic      grant_q, prot_q;

   swp_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_ADDR_W(CMP_ADDR_W)
   ) u_match (
      .addr(wr_addr), .data(wr_data), .tok(tok)
   );

   swp_tracker u_track (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .bypass(grant_q),
      .tok(tok), .cur_step(cur_step), .step_hit(step_hit),
      .done_unlock(done_unlock), .done_release(done_release)
   );

   swp_guard u_guard (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
      .window_expired(window_expired), .cur_step(cur_step),
      .step_hit(step_hit), .done_unlock(done_unlock),
      .done_release(done_release), .grant_q(grant_q), .prot_q(prot_q),
      .dec_valid(dec_valid), .dec_pass(dec_pass), .dec_cmd(dec_cmd)
   );

   assign prot_active = prot_q;
endmodule

// File: rtl/swp_gate_chk.sv
module swp_gate_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_valid,
   input logic window_expired,
   input logic dec_valid,
   input logic dec_pass,
   input logic dec_cmd,
   input logic prot_active,
   input logic grant
);
   p_cmd_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_cmd |-> !dec_pass);

   p_prot_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_active) |-> dec_valid && dec_pass && !dec_cmd);

   p_prot_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_active) |-> dec_valid && dec_cmd);

   p_block_when_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_pass |-> !$past(prot_active) || $past(grant));

   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_pass && !dec_cmd);

   p_grant_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(window_expired) && !$past(wr_valid) |-> !grant);
endmodule

bind swp_gate swp_gate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
   .window_expired(window_expired), .dec_valid(dec_valid),
   .dec_pass(dec_pass), .dec_cmd(dec_cmd), .prot_active(prot_active),
   .grant(grant_q)
);

// File: tb/swp_gate_bench.sv
module swp_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        window_expired = 1'b0;
   logic        dec_valid, dec_pass, dec_cmd, prot_active;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [1:0] q_exp[$];
   string      q_tag[$];

   always #5 clk = ~clk;

   swp_gate u_swp_gate (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .window_expired(window_expired),
      .dec_valid(dec_valid), .dec_pass(dec_pass), .dec_cmd(dec_cmd),
      .prot_active(prot_active)
   );

   // driver: one write per call, expected {pass,cmd} queued
   task automatic wr(input logic [16:0] a, input logic [31:0] d,
                     input bit ep, input bit ec, input string tag);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d;
      q_exp.push_back({ep, ec});
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_valid = 1'b0;
      end
   endtask

   task automatic expire();
      @(negedge clk);
      wr_valid = 1'b0;
      window_expired = 1'b1;
      @(negedge clk);
      window_expired = 1'b0;
   endtask

   task automatic chk_prot(input bit e, input string tag);
      checks++;
      if (prot_active !== e) begin
         errors++;
         $display("FAIL %s prot_active actual=%0b expected=%0b", tag, prot_active, e);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         checks++;
         if (q_exp.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected decision actual=%0b%0b expected=none",
                     dec_pass, dec_cmd);
         end else begin
            logic [1:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            if ({dec_pass, dec_cmd} !== e) begin
               errors++;
               $display("FAIL %s pass/cmd actual=%0b%0b expected=%0b%0b",
                        t, dec_pass, dec_cmd, e[1], e[0]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (dec_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 dec_valid actual=%0b expected=0", dec_valid);
      end
      chk_prot(1'b0, "R1");
      rst_n = 1'b1;
      idle(1);

      // R2 ordinary write, protection off
      wr(17'h00100, 32'h12345678, 1, 0, "R2");
      // R11 / R3 prefix with protection off
      wr(17'h05555, 32'h000000AA, 1, 0, "R11");
      wr(17'h02AAA, 32'h00000055, 1, 0, "R11");
      wr(17'h05555, 32'h000000A0, 0, 1, "R3");
      idle(1);
      chk_prot(1'b0, "R3");
      // R4 data write after prefix
      wr(17'h00200, 32'hCAFE0001, 1, 0, "R4");
      idle(1);
      chk_prot(1'b1, "R4");
      wr(17'h00201, 32'hCAFE0002, 1, 0, "R6");
      expire();
      wr(17'h00300, 32'h00000003, 0, 0, "R6");
      // R5 protected: sequence byte is command, stray write blocked
      wr(17'h05555, 32'h000000AA, 0, 1, "R5");
      wr(17'h01234, 32'h00000055, 0, 0, "R8");
      wr(17'h00400, 32'h00000004, 0, 0, "R5");
      // R9 / R10 prefix with high address bit, dirty data, alternate address
      wr(17'h15555, 32'hDEAD00AA, 0, 1, "R9");
      wr(17'h0AAAA, 32'hBEEF0055, 0, 1, "R10");
      wr(17'h05555, 32'h000000A0, 0, 1, "R3");
      wr(17'h00500, 32'h00000005, 1, 0, "R4");
      idle(1);
      chk_prot(1'b1, "R4");
      expire();
      // R7 release while protected
      wr(17'h05555, 32'h000000AA, 0, 1, "R7");
      wr(17'h02AAA, 32'h00000055, 0, 1, "R7");
      wr(17'h05555, 32'h00000080, 0, 1, "R7");
      wr(17'h05555, 32'h000000AA, 0, 1, "R7");
      wr(17'h02AAA, 32'h00000055, 0, 1, "R7");
      wr(17'h05555, 32'h00000020, 0, 1, "R7");
      idle(1);
      chk_prot(1'b0, "R7");
      wr(17'h00600, 32'h00000006, 1, 0, "R7");
      // R7 / R11 release while unprotected
      wr(17'h05555, 32'h000000AA, 1, 0, "R11");
      wr(17'h02AAA, 32'h00000055, 1, 0, "R11");
      wr(17'h05555, 32'h00000080, 0, 1, "R7");
      wr(17'h05555, 32'h000000AA, 0, 1, "R7");
      wr(17'h0AAAA, 32'h00000055, 0, 1, "R7");
      wr(17'h05555, 32'h00000020, 0, 1, "R7");
      idle(1);
      chk_prot(1'b0, "R7");
      // R8 broken prefix, protection off: all ordinary
      wr(17'h05555, 32'h000000AA, 1, 0, "R8");
      wr(17'h00777, 32'h00000055, 1, 0, "R8");
      wr(17'h02AAA, 32'h00000055, 1, 0, "R8");
      wr(17'h05555, 32'h000000A0, 1, 0, "R8");
      wr(17'h00800, 32'h00000008, 1, 0, "R8");
      idle(2);
      chk_prot(1'b0, "R8");

      checks++;
      if (q_exp.size() != 0) begin
         errors++;
         $display("FAIL R2 missing decisions actual=%0d expected=0", q_exp.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule